// File: doc/BRIEF.md
# Embedded-Sync Line Interrupt Generator

This block watches an 8-bit digital video byte stream that carries its timing in-band and raises an interrupt on one chosen line of every field. It finds the four-byte timing reference codes in the stream. From the vertical-blanking flag of each start-of-active-video code it rebuilds a vertical sync level. It then counts lines from the rising edge of that level and pulses `irq` on the clock in which the count first equals `cmp_line`.

Three sources can drive the line counter. The first is the embedded codes. The second is a pair of external vertical and horizontal sync pins. The third is an internal free-running generator, used when the sync direction is set to output, in which case the block also drives its own sync pulses. Setting `cmp_line` a few lines past zero hides any toggling of the vertical flag during blanking from the interrupt.

The code detector is a four-state machine. HUNT goes to SAW_FF on byte FF. SAW_FF goes to SAW_Z1 on 00, stays on FF, and otherwise returns to HUNT. SAW_Z1 goes to SAW_Z2 on 00, goes back to SAW_FF on FF, and otherwise returns to HUNT. SAW_Z2 always leaves: it goes to SAW_FF on FF and to HUNT on any other byte, and it reports a code when the byte has bit 7 set. The source selector has three states. SRC_EMBED is used when `dir_out`=0 and `ext_sel`=0, SRC_EXT when `dir_out`=0 and `ext_sel`=1, and SRC_GEN when `dir_out`=1.

Top module: `vsync_line_irq`

## Requirements
- R1: A timing code is the byte run FF, 00, 00, XY with XY bit 7 = 1 (bit 6 field, bit 5 vertical flag V, bit 4 code type H). An XY with bit 7 = 0, or a broken run such as FF 00 01, is not a code. An FF inside a partial run restarts the match, so FF FF 00 00 XY and FF 00 FF 00 00 XY are both codes.
- R2: A code with H=0 is start-of-active-video (SAV). The derived vertical sync takes the V of SAV codes only. The V of a code with H=1 (end-of-active-video) has no effect.
- R3: The line counter adds one per SAV. It is cleared to 0 instead when the derived vertical sync rises, that is, when an SAV has V=1 and the previous SAV had V=0.
- R4: `irq` is high for exactly one clock each time the counter arrives at `cmp_line`. In embedded mode it is high right after the second clock edge following the edge that samples XY.
- R5: A well-formed stream with `cmp_line`=0 gives exactly one interrupt per field.
- R6: With `cmp_line`=2, V toggling at alternate SAVs during blanking gives exactly one interrupt per field.
- R7: With `dir_out`=0 and `ext_sel`=1, the `ext_vsync` level is the vertical sync and each rising edge of `ext_hsync` counts one line. Embedded codes are ignored. `irq` is high right after the first edge following the edge that samples `ext_hsync` high.
- R8: With `dir_out`=1, stream codes and external pins are ignored. A generator runs with fields of `gen_lines` lines of `gen_pixels` clocks each, and `irq` repeats every `gen_lines`*`gen_pixels` clocks. `sync_oe`=1. `vd_out` is high during generated line 0 and `hd_out` during clock 0 of each line, so a field period holds `gen_pixels` vd_out cycles and `gen_lines` hd_out cycles.
- R9: With `dir_out`=0, `sync_oe`, `vd_out` and `hd_out` are 0.
- R10: Synchronous active-high `rst` clears the counter, the sync state, `irq` and the code detector. A run cut by reset does not complete afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst | input | 1 | synchronous reset, active high |
| pix_byte | input | 8 | video byte stream |
| dir_out | input | 1 | sync direction: 0 input, 1 output (generator) |
| ext_sel | input | 1 | in input direction: 0 embedded codes, 1 external pins |
| ext_vsync | input | 1 | external vertical sync level |
| ext_hsync | input | 1 | external horizontal sync, rising edge counts a line |
| cmp_line | input | LINE_W | line number that raises the interrupt |
| gen_lines | input | LINE_W | generator lines per field |
| gen_pixels | input | PIX_W | generator clocks per line |
| irq | output | 1 | one-clock interrupt pulse |
| sync_oe | output | 1 | high when the block drives its sync outputs |
| vd_out | output | 1 | generated vertical sync |
| hd_out | output | 1 | generated horizontal sync |

## Verification
If the detector keeps a partial match, the line counter drifts or the vertical sync level is wrong, the `irq` pulse moves to a different clock from the one the code stream predicts. The scoreboard therefore compares the exact cycle of every pulse, not just how many pulses occur. A false code detection or a missed clear appears at the latest when the counter next passes the compare line, which is within one field. A generator error appears as a wrong pulse spacing at the second interrupt, or as wrong `vd_out`/`hd_out` duty within one field period.

// File: rtl/vsl_pkg.sv
package vsl_pkg;
    typedef enum logic [1:0] {
        HUNT   = 2'd0,
        SAW_FF = 2'd1,
        SAW_Z1 = 2'd2,
        SAW_Z2 = 2'd3
    } trc_state_e;

    typedef enum logic [1:0] {
        SRC_EMBED = 2'd0,
        SRC_EXT   = 2'd1,
        SRC_GEN   = 2'd2
    } sync_src_e;

    localparam logic [7:0] TRC_ONES  = 8'hFF;
    localparam logic [7:0] TRC_ZERO  = 8'h00;
    localparam int         XY_MARK   = 7;
    localparam int         XY_VFLAG  = 5;
    localparam int         XY_HFLAG  = 4;
endpackage

// File: rtl/vsl_trc_detect.sv
module vsl_trc_detect
    import vsl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] din,
    output logic       code_stb,
    output logic       code_v,
    output logic       code_h
);
    trc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= HUNT;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = HUNT;
        unique case (state_q)
            HUNT:   state_d = (din == TRC_ONES) ? SAW_FF : HUNT;
            SAW_FF: begin
                if (din == TRC_ZERO)      state_d = SAW_Z1;
                else if (din == TRC_ONES) state_d = SAW_FF;
                else                      state_d = HUNT;
            end
            SAW_Z1: begin
                if (din == TRC_ZERO)      state_d = SAW_Z2;
                else if (din == TRC_ONES) state_d = SAW_FF;
                else                      state_d = HUNT;
            end
            SAW_Z2: state_d = (din == TRC_ONES) ? SAW_FF : HUNT;
            default: state_d = HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_stb <= 1'b0;
            code_v   <= 1'b0;
            code_h   <= 1'b0;
        end else begin
            code_stb <= (state_q == SAW_Z2) && din[XY_MARK];
            if ((state_q == SAW_Z2) && din[XY_MARK]) begin
                code_v <= din[XY_VFLAG];
                code_h <= din[XY_HFLAG];
            end
        end
    end
endmodule

// File: rtl/vsl_sync_gen.sv
module vsl_sync_gen #(
    parameter int LINE_W = 11,
    parameter int PIX_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] gen_lines,
    input  logic [PIX_W-1:0]  gen_pixels,
    output logic              gen_v,
    output logic              gen_h,
    output logic              gen_tick
);
    logic [PIX_W-1:0]  pix_q;
    logic [LINE_W-1:0] line_q;
    logic              pix_last, line_last;

    always_comb begin
        pix_last  = (pix_q  >= gen_pixels - 1'b1);
        line_last = (line_q >= gen_lines  - 1'b1);
        gen_v     = (line_q == '0);
        gen_h     = (pix_q  == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q    <= '0;
            line_q   <= '0;
            gen_tick <= 1'b0;
        end else begin
            gen_tick <= pix_last;
            if (pix_last) begin
                pix_q  <= '0;
                line_q <= line_last ? '0 : line_q + 1'b1;
            end else begin
                pix_q  <= pix_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vsl_line_irq.sv
module vsl_line_irq #(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_v,
    input  logic              line_tick,
    input  logic [LINE_W-1:0] cmp_line,
    output logic [LINE_W-1:0] cnt,
    output logic              irq
);
    logic              vs_q, rising, load;
    logic [LINE_W-1:0] cnt_next;

    always_comb begin
        rising   = sync_v & ~vs_q;
        load     = rising | line_tick;
        cnt_next = rising ? '0 : cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_q <= 1'b0;
            cnt  <= '0;
            irq  <= 1'b0;
        end else begin
            vs_q <= sync_v;
            irq  <= load && (cnt_next == cmp_line);
            if (load) cnt <= cnt_next;
        end
    end
endmodule

// File: rtl/vsync_line_irq.sv
module vsync_line_irq
    import vsl_pkg::*;
#(
    parameter int LINE_W = 11,
    parameter int PIX_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        pix_byte,
    input  logic              dir_out,
    input  logic              ext_sel,
    input  logic              ext_vsync,
    input  logic              ext_hsync,
    input  logic [LINE_W-1:0] cmp_line,
    input  logic [LINE_W-1:0] gen_lines,
    input  logic [PIX_W-1:0]  gen_pixels,
    output logic              irq,
    output logic              sync_oe,
    output logic              vd_out,
    output logic              hd_out
);
    logic              code_stb, code_v, code_h;
    logic              emb_v, emb_tick;
    logic              ext_v_r, ext_h_r, ext_h_q;
    logic              gen_v, gen_h, gen_tick;
    logic              sel_v, sel_tick;
    logic [LINE_W-1:0] cnt;
    sync_src_e         src;

    vsl_trc_detect u_detect (
        .clk      (clk),
        .rst      (rst),
        .din      (pix_byte),
        .code_stb (code_stb),
        .code_v   (code_v),
        .code_h   (code_h)
    );

    // embedded path: only SAV codes move the sync level and the line tick
    always_ff @(posedge clk) begin
        if (rst) begin
            emb_v    <= 1'b0;
            emb_tick <= 1'b0;
        end else begin
            emb_tick <= code_stb & ~code_h;
            if (code_stb & ~code_h) emb_v <= code_v;
        end
    end

    // external pin path: one register stage, then edge detect on hsync
    always_ff @(posedge clk) begin
        if (rst) begin
            ext_v_r <= 1'b0;
            ext_h_r <= 1'b0;
            ext_h_q <= 1'b0;
        end else begin
            ext_v_r <= ext_vsync;
            ext_h_r <= ext_hsync;
            ext_h_q <= ext_h_r;
        end
    end

    vsl_sync_gen #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_gen (
        .clk        (clk),
        .rst        (rst),
        .gen_lines  (gen_lines),
        .gen_pixels (gen_pixels),
        .gen_v      (gen_v),
        .gen_h      (gen_h),
        .gen_tick   (gen_tick)
    );

    always_comb begin
        if (dir_out)      src = SRC_GEN;
        else if (ext_sel) src = SRC_EXT;
        else              src = SRC_EMBED;
    end

    always_comb begin
        sel_v    = 1'b0;
        sel_tick = 1'b0;
        unique case (src)
            SRC_EMBED: begin sel_v = emb_v;   sel_tick = emb_tick;           end
            SRC_EXT:   begin sel_v = ext_v_r; sel_tick = ext_h_r & ~ext_h_q; end
            SRC_GEN:   begin sel_v = gen_v;   sel_tick = gen_tick;           end
            default:   begin sel_v = 1'b0;    sel_tick = 1'b0;               end
        endcase
    end

    vsl_line_irq #(.LINE_W(LINE_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .sync_v    (sel_v),
        .line_tick (sel_tick),
        .cmp_line  (cmp_line),
        .cnt       (cnt),
        .irq       (irq)
    );

    always_comb begin
        sync_oe = dir_out;
        vd_out  = dir_out & gen_v;
        hd_out  = dir_out & gen_h;
    end
endmodule

// File: rtl/vsl_checker.sv
module vsl_checker #(
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        pix_byte,
    input logic              code_stb,
    input logic              sel_v,
    input logic [LINE_W-1:0] cnt,
    input logic [LINE_W-1:0] cmp_line,
    input logic              irq,
    input logic              dir_out,
    input logic              vd_out,
    input logic              hd_out
);
    // R1
    code_mark_chk: assert property (@(posedge clk) disable iff (rst)
        code_stb |-> $past(pix_byte[7]));

    // R3
    sync_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_v) |=> (cnt == '0));

    // R4
    irq_match_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cnt == $past(cmp_line)));

    // R4
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R8
    vd_align_chk: assert property (@(posedge clk) disable iff (rst)
        (dir_out && $past(dir_out) && vd_out && !$past(vd_out)) |-> hd_out);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cnt == '0 && !irq));
endmodule

bind vsync_line_irq vsl_checker #(.LINE_W(LINE_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .pix_byte (pix_byte),
    .code_stb (code_stb),
    .sel_v    (sel_v),
    .cnt      (cnt),
    .cmp_line (cmp_line),
    .irq      (irq),
    .dir_out  (dir_out),
    .vd_out   (vd_out),
    .hd_out   (hd_out)
);

// File: tb/vsync_line_irq_tb_top.sv
module vsync_line_irq_tb_top;
    localparam int LW = 11;
    localparam int PW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    pix = 8'h10;
    logic          dir_out = 1'b0, ext_sel = 1'b0;
    logic          ext_vsync = 1'b0, ext_hsync = 1'b0;
    logic [LW-1:0] cmp_line = '0;
    logic [LW-1:0] gen_lines = 11'd5;
    logic [PW-1:0] gen_pixels = 12'd8;
    logic          irq, sync_oe, vd_out, hd_out;

    int checks = 0, failures = 0;
    int cyc = 0;
    int exp_q[$];
    int seen = 0;
    int m_line = 0;
    bit m_prev = 1'b0;
    bit gen_mode = 1'b0;
    int last_irq = -1;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vsync_line_irq #(.LINE_W(LW), .PIX_W(PW)) dut_i (
        .clk(clk), .rst(rst), .pix_byte(pix), .dir_out(dir_out), .ext_sel(ext_sel),
        .ext_vsync(ext_vsync), .ext_hsync(ext_hsync), .cmp_line(cmp_line),
        .gen_lines(gen_lines), .gen_pixels(gen_pixels),
        .irq(irq), .sync_oe(sync_oe), .vd_out(vd_out), .hd_out(hd_out));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor: pops expected interrupt cycles, or checks spacing in generator mode
    always @(negedge clk) begin
        if (!rst && irq) begin
            seen++;
            if (gen_mode) begin
                if (last_irq >= 0)
                    check(cyc - last_irq == gen_lines * gen_pixels, "R8 irq spacing",
                          cyc - last_irq, gen_lines * gen_pixels);
                last_irq = cyc;
            end else if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected irq", cyc, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(cyc == e, "R4 irq cycle", cyc, e);
            end
        end
    end

    // model of the counter, from R2/R3/R4/R7
    task automatic model_tick(input bit v, input int due);
        if (gen_mode) return;
        if (v && !m_prev) m_line = 0;
        else              m_line = m_line + 1;
        m_prev = v;
        if (m_line == int'(cmp_line)) exp_q.push_back(due);
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        pix = b;
    endtask

    task automatic code(input bit v, input bit h, input bit track);
        put(8'hFF); put(8'h00); put(8'h00);
        put({1'b1, 1'b0, v, h, 4'h0});
        if (track && !h) model_tick(v, cyc + 3);
        put(8'h10); put(8'h80); put(8'h10); put(8'h80);
    endtask

    task automatic ext_pulse(input bit v);
        @(negedge clk);
        ext_vsync = v; ext_hsync = 1'b1;
        model_tick(v, cyc + 2);
        @(negedge clk);
        ext_hsync = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        m_line = 0; m_prev = 1'b0; seen = 0; last_irq = -1;
        rst = 1'b0;
    endtask

    task automatic drain(input string req);
        repeat (8) @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R10 / R9: reset state
        repeat (3) @(negedge clk);
        check(irq == 1'b0, "R10 irq in reset", irq, 0);
        rst = 1'b0;
        @(negedge clk);
        check(sync_oe == 0 && vd_out == 0 && hd_out == 0, "R9 idle outputs",
              {sync_oe, vd_out, hd_out}, 0);

        // R5, R2, R3: three clean fields, blanking V=1 on lines 0..3, EAV always V=1
        cmp_line = 11'd0;
        for (int f = 0; f < 3; f++)
            for (int l = 0; l < 20; l++) begin
                code(1'b1, 1'b1, 1'b1);
                code(l < 4, 1'b0, 1'b1);
            end
        drain("R3 pending irqs");
        check(seen == 3, "R5 one irq per field", seen, 3);
        check(sync_oe == 0 && vd_out == 0, "R9 input direction", {sync_oe, vd_out}, 0);

        // R6: V toggling in blanking, compare line 2
        do_reset();
        cmp_line = 11'd2;
        for (int f = 0; f < 2; f++)
            for (int l = 0; l < 20; l++)
                code((l < 6) ? (l % 2 == 0) : 1'b0, 1'b0, 1'b1);
        drain("R6 pending irqs");
        check(seen == 2, "R6 one irq per field", seen, 2);

        // R10: partial code cut by reset must not complete
        cmp_line = 11'd3;
        put(8'hFF); put(8'h00); put(8'h00);
        @(negedge clk); rst = 1'b1; pix = 8'h00;
        repeat (2) @(negedge clk);
        m_line = 0; m_prev = 1'b0; seen = 0;
        rst = 1'b0;
        pix = 8'h80;
        repeat (6) @(negedge clk);
        check(seen == 0 && irq == 0, "R10 no stale code", seen, 0);

        // R1: malformed runs ignored, restarts accepted; irq expected on third real SAV
        put(8'hFF); put(8'h00); put(8'h00); put(8'h20); put(8'h10);
        put(8'hFF); put(8'h00); put(8'h01); put(8'h80); put(8'h10);
        code(1'b0, 1'b0, 1'b1);
        put(8'hFF); put(8'hFF); put(8'h00); put(8'h00); put(8'h80);
        model_tick(1'b0, cyc + 3); put(8'h10);
        put(8'hFF); put(8'h00); put(8'hFF); put(8'h00); put(8'h00); put(8'h80);
        model_tick(1'b0, cyc + 3); put(8'h10);
        drain("R1 code recognition");
        check(seen == 1, "R1 irq count", seen, 1);

        // R7: external pins, embedded codes ignored
        ext_sel = 1'b1;
        do_reset();
        cmp_line = 11'd2;
        ext_pulse(1'b1);
        code(1'b1, 1'b0, 1'b0);
        code(1'b0, 1'b0, 1'b0);
        code(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) ext_pulse(1'b0);
        ext_pulse(1'b1);
        for (int i = 0; i < 3; i++) ext_pulse(1'b0);
        drain("R7 pending irqs");
        check(seen == 2, "R7 irq count", seen, 2);

        // R8: generator, stream and pins ignored
        ext_sel = 1'b0;
        dir_out = 1'b1;
        gen_mode = 1'b1;
        do_reset();
        cmp_line = 11'd3;
        @(negedge clk);
        check(sync_oe == 1'b1, "R8 sync_oe", sync_oe, 1);
        begin
            int nv = 0, nh = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                nv += vd_out; nh += hd_out;
            end
            check(nv == 8, "R8 vd_out cycles", nv, 8);
            check(nh == 5, "R8 hd_out cycles", nh, 5);
        end
        for (int i = 0; i < 6; i++) begin
            code(i % 2, 1'b0, 1'b0);
            ext_pulse(i % 2 == 0);
        end
        repeat (60) @(negedge clk);
        check(seen >= 4, "R8 irq count", seen, 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule